// File: doc/BRIEF.md
# Two-Pixel 16-bit RGB Unpacker

This block sits between a frame-buffer fetch path and a pixel pipeline. Each accepted 32-bit word holds two 16-bit pixels. The block sends them out one at a time as 24-bit RGB values. The layout of each pixel is resolved from several inputs: the controller variant, a 2-bit external layout-select input, a format pin that only the extended variant uses, and the red/blue swap control. That gives either a 5-5-5 layout with one spare bit or a 5-6-5 layout. Two endian controls set which half of the word is sent first and whether the two bytes of each pixel are exchanged. The byte control overrides the pixel control.

A small state machine does the sequencing. In `ST_IDLE` the block offers `in_ready`. An input handshake (transition *accept*) stores the word and a snapshot of every control input, and moves to `ST_FIRST`. In `ST_FIRST` the first pixel is presented, and an output handshake (transition *first_taken*) moves to `ST_SECOND`. In `ST_SECOND` the second pixel is presented, and an output handshake (transition *second_taken*) returns to `ST_IDLE`. While an output is offered and not taken, the state and data hold.

Top module: `px16_unpacker`

## Requirements
- R1: While reset is asserted and directly after it is released, `in_ready` is 1 and `out_valid` is 0.
- R2: A word is taken when `in_valid` and `in_ready` are both high at a clock edge. Its two pixels then leave on the next two output handshakes (`out_valid` and `out_ready` high), first pixel then second. `in_ready` stays low and `out_valid` stays high until the second pixel leaves. `out_rgb` does not change while `out_valid` is high and `out_ready` is low.
- R3: With both endian controls low, the first pixel is word bits [15:0] and the second is bits [31:16].
- R4: With `cfg_be_pix`=1 and `cfg_be_byte`=0, the first pixel is word bits [31:16] and the second is bits [15:0].
- R5: With `cfg_be_byte`=1, the first pixel is {w[23:16], w[31:24]} and the second is {w[7:0], w[15:8]}, whatever the value of `cfg_be_pix`.
- R6: In the 5-5-5 layout the fields are low=[4:0], mid=[9:5], high=[14:10], and bit 15 is ignored. In the 5-6-5 layout the fields are low=[4:0], green=[10:5], high=[15:11].
- R7: Each 5-bit field is widened to 8 bits by a left shift of 3, and the 6-bit green field by a left shift of 2, zero-filled. `out_rgb` is {R[23:16], G[15:8], B[7:0]}. Without swap, R is the low field and B is the high field.
- R8: When the swap is in force, R is the high field and B is the low field.
- R9: With `cfg_ext_variant`=0 and `mux_sel`=1, the layout is 5-5-5 and the swap follows `cfg_rb_swap`.
- R10: With `cfg_ext_variant`=0 and `mux_sel`=3, the layout is 5-6-5 and the swap is always in force.
- R11: With `cfg_ext_variant`=0 and `mux_sel` equal to 0 or 2, the layout is 5-6-5 and the swap follows `cfg_rb_swap`.
- R12: With `cfg_ext_variant`=1, `cfg_fmt565`=1 selects 5-6-5 and 0 selects 5-5-5, the swap follows `cfg_rb_swap`, and `mux_sel` has no effect.
- R13: Control inputs are sampled at the input handshake. Changing them while the word's pixels are pending does not change those pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Two packed 16-bit pixels |
| cfg_ext_variant | input | 1 | 1 selects the extended variant |
| cfg_fmt565 | input | 1 | Extended variant: 1 means 5-6-5, 0 means 5-5-5 |
| cfg_rb_swap | input | 1 | Red/blue swap request |
| cfg_be_byte | input | 1 | Big-endian byte order (overrides pixel order) |
| cfg_be_pix | input | 1 | Big-endian pixel order |
| mux_sel | input | 2 | External layout select (basic variant only) |
| out_valid | output | 1 | Pixel offered |
| out_ready | input | 1 | Consumer takes the pixel |
| out_rgb | output | 24 | Pixel as {R,G,B}, 8 bits each |

## Verification
A wrong state register appears at the handshake ports on the very next edge. `in_ready` and `out_valid` are decoded directly from the state, so a missed or extra transition shows up as a lost pixel, a duplicated pixel or an early reload within one cycle. A corrupt stored word or control snapshot appears on `out_rgb` at the next output handshake. The bench's cycle model checks both the flags and the data on every clock, under steady and random back-pressure.

// File: rtl/px16_pkg.sv
package px16_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } px_state_e;

    typedef enum logic {
        LAY_5551 = 1'b0,
        LAY_565  = 1'b1
    } px_layout_e;

    typedef struct packed {
        logic       ext_variant;
        logic       fmt565;
        logic       rb_swap;
        logic       be_byte;
        logic       be_pix;
        logic [1:0] mux;
    } px_ctl_t;

endpackage

// File: rtl/px16_layout_sel.sv
module px16_layout_sel
    import px16_pkg::*;
(
    input  px_ctl_t    ctl,
    output px_layout_e layout,
    output logic       swap_rb
);
    always_comb begin
        layout  = LAY_565;
        swap_rb = ctl.rb_swap;
        if (ctl.ext_variant) begin
            layout  = ctl.fmt565 ? LAY_565 : LAY_5551;
            swap_rb = ctl.rb_swap;
        end else begin
            unique case (ctl.mux)
                2'd1: begin
                    layout  = LAY_5551;
                    swap_rb = ctl.rb_swap;
                end
                2'd3: begin
                    layout  = LAY_565;
                    swap_rb = 1'b1;
                end
                default: begin
                    layout  = LAY_565;
                    swap_rb = ctl.rb_swap;
                end
            endcase
        end
    end
endmodule

// File: rtl/px16_lane_pick.sv
module px16_lane_pick #(
    parameter int PIX_W  = 16,
    parameter int LANES  = 2,
    parameter int BYTE_W = 8,
    localparam int WORD_W = PIX_W * LANES,
    localparam int NBYTES = PIX_W / BYTE_W,
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic              be_byte,
    input  logic              be_pix,
    input  logic [IDX_W-1:0]  idx,
    output logic [PIX_W-1:0]  pix
);
    logic [PIX_W-1:0] lane  [LANES];
    logic [PIX_W-1:0] bswap [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = word[i*PIX_W +: PIX_W];
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign bswap[i][b*BYTE_W +: BYTE_W] = lane[i][(NBYTES-1-b)*BYTE_W +: BYTE_W];
        end
    end

    logic [IDX_W-1:0] rev;

    always_comb begin
        rev = IDX_W'(LANES - 1) - idx;
        if (be_byte) begin
            pix = bswap[rev];
        end else if (be_pix) begin
            pix = lane[rev];
        end else begin
            pix = lane[idx];
        end
    end
endmodule

// File: rtl/px16_expand.sv
module px16_expand
    import px16_pkg::*;
#(
    parameter int PIX_W = 16,
    parameter int CH_W  = 8,
    localparam int RGB_W = 3 * CH_W
) (
    input  logic [PIX_W-1:0] pix,
    input  px_layout_e       layout,
    input  logic             swap_rb,
    output logic [RGB_W-1:0] rgb
);
    logic [4:0]      lo_f;
    logic [4:0]      hi_f;
    logic [4:0]      g5;
    logic [5:0]      g6;
    logic [CH_W-1:0] lo8;
    logic [CH_W-1:0] hi8;
    logic [CH_W-1:0] g8;

    always_comb begin
        lo_f = pix[4:0];
        g5   = pix[9:5];
        g6   = pix[10:5];
        hi_f = (layout == LAY_565) ? pix[15:11] : pix[14:10];
        lo8  = {lo_f, {(CH_W-5){1'b0}}};
        hi8  = {hi_f, {(CH_W-5){1'b0}}};
        g8   = (layout == LAY_565) ? {g6, {(CH_W-6){1'b0}}} : {g5, {(CH_W-5){1'b0}}};
        if (swap_rb) begin
            rgb = {hi8, g8, lo8};
        end else begin
            rgb = {lo8, g8, hi8};
        end
    end
endmodule

// File: rtl/px16_unpacker.sv
module px16_unpacker
    import px16_pkg::*;
#(
    parameter int PIX_W = 16,
    parameter int LANES = 2,
    parameter int CH_W  = 8,
    localparam int WORD_W = PIX_W * LANES,
    localparam int RGB_W  = 3 * CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              cfg_ext_variant,
    input  logic              cfg_fmt565,
    input  logic              cfg_rb_swap,
    input  logic              cfg_be_byte,
    input  logic              cfg_be_pix,
    input  logic [1:0]        mux_sel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [RGB_W-1:0]  out_rgb
);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    px_state_e         state_q, state_d;
    logic [WORD_W-1:0] word_q;
    px_ctl_t           ctl_q;
    px_ctl_t           ctl_in;
    logic              take_in;
    logic              take_out;
    logic [IDX_W-1:0]  lane_idx;
    logic [PIX_W-1:0]  pix;
    px_layout_e        layout;
    logic              swap_rb;

    assign ctl_in = '{ext_variant: cfg_ext_variant, fmt565: cfg_fmt565,
                      rb_swap: cfg_rb_swap, be_byte: cfg_be_byte,
                      be_pix: cfg_be_pix, mux: mux_sel};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_in)  state_d = ST_FIRST;
            ST_FIRST:  if (take_out) state_d = ST_SECOND;
            ST_SECOND: if (take_out) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Word and control snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            ctl_q  <= '0;
        end else if (take_in) begin
            word_q <= in_word;
            ctl_q  <= ctl_in;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        in_ready = 1'b0;
        out_valid = 1'b0;
        lane_idx = '0;
        unique case (state_q)
            ST_IDLE:   in_ready = 1'b1;
            ST_FIRST:  out_valid = 1'b1;
            ST_SECOND: begin
                out_valid = 1'b1;
                lane_idx  = IDX_W'(1);
            end
            default:   in_ready = 1'b0;
        endcase
        take_in  = in_valid && in_ready;
        take_out = out_valid && out_ready;
    end

    px16_layout_sel u_layout (
        .ctl     (ctl_q),
        .layout  (layout),
        .swap_rb (swap_rb)
    );

    px16_lane_pick #(.PIX_W(PIX_W), .LANES(LANES)) u_pick (
        .word    (word_q),
        .be_byte (ctl_q.be_byte),
        .be_pix  (ctl_q.be_pix),
        .idx     (lane_idx),
        .pix     (pix)
    );

    px16_expand #(.PIX_W(PIX_W), .CH_W(CH_W)) u_expand (
        .pix     (pix),
        .layout  (layout),
        .swap_rb (swap_rb),
        .rgb     (out_rgb)
    );
endmodule

// File: rtl/px16_unpacker_chk.sv
module px16_unpacker_chk #(
    parameter int RGB_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [RGB_W-1:0] out_rgb
);
    logic second_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            second_pend <= 1'b0;
        end else if (in_valid && in_ready) begin
            second_pend <= 1'b0;
        end else if (out_valid && out_ready) begin
            second_pend <= ~second_pend;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && !out_valid));

    assert_no_ready_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_accept_gives_pixel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !in_ready));

    assert_hold_when_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

    assert_first_then_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !second_pend) |=> (out_valid && !in_ready));

    assert_reload_after_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && second_pend) |=> (in_ready && !out_valid));
endmodule

bind px16_unpacker px16_unpacker_chk #(.RGB_W(RGB_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rgb   (out_rgb)
);

// File: tb/px16_unpacker_bench.sv
`timescale 1ns/1ps
module px16_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        cfg_ext_variant = 1'b0;
    logic        cfg_fmt565 = 1'b0;
    logic        cfg_rb_swap = 1'b0;
    logic        cfg_be_byte = 1'b0;
    logic        cfg_be_pix = 1'b0;
    logic [1:0]  mux_sel = 2'd0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_rgb;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    int    stall_mode = 0;   // 0 always ready, 1 random, 2 held low
    string cur_tag = "R3";

    logic [23:0] q_rgb[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    px16_unpacker u_px16_unpacker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .cfg_ext_variant(cfg_ext_variant), .cfg_fmt565(cfg_fmt565),
        .cfg_rb_swap(cfg_rb_swap), .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix),
        .mux_sel(mux_sel), .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb)
    );

    function automatic logic [23:0] model_pix(logic [31:0] w, bit ext, bit fmt, bit bgr,
                                              bit beb, bit bep, logic [1:0] mx, bit second);
        logic [15:0] p;
        bit is565, sw;
        int lo, hi, gr;
        if (beb)      p = second ? {w[7:0], w[15:8]} : {w[23:16], w[31:24]};
        else if (bep) p = second ? w[15:0] : w[31:16];
        else          p = second ? w[31:16] : w[15:0];
        if (ext) begin
            is565 = fmt; sw = bgr;
        end else if (mx == 2'd1) begin
            is565 = 0; sw = bgr;
        end else if (mx == 2'd3) begin
            is565 = 1; sw = 1;
        end else begin
            is565 = 1; sw = bgr;
        end
        lo = int'(p[4:0]) * 8;
        if (is565) begin
            gr = int'(p[10:5]) * 4;
            hi = int'(p[15:11]) * 8;
        end else begin
            gr = int'(p[9:5]) * 8;
            hi = int'(p[14:10]) * 8;
        end
        if (sw) return {hi[7:0], gr[7:0], lo[7:0]};
        return {lo[7:0], gr[7:0], hi[7:0]};
    endfunction

    // Cycle model: compare, then advance with the handshakes of the coming edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                vectors++;
                if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
                    miscompares++;
                    $display("FAIL R1 in reset: actual rdy=%b vld=%b expected rdy=1 vld=0",
                             in_ready, out_valid);
                end
            end else begin
                bit exp_v;
                exp_v = (q_rgb.size() != 0);
                vectors++;
                if (out_valid !== exp_v || in_ready !== !exp_v) begin
                    miscompares++;
                    $display("FAIL R2 flags: actual vld=%b rdy=%b expected vld=%b rdy=%b",
                             out_valid, in_ready, exp_v, !exp_v);
                end else if (exp_v && out_rgb !== q_rgb[0]) begin
                    miscompares++;
                    $display("FAIL %s pixel: actual %06h expected %06h",
                             q_tag[0], out_rgb, q_rgb[0]);
                end
                if (exp_v && out_ready) begin
                    void'(q_rgb.pop_front());
                    void'(q_tag.pop_front());
                end else if (!exp_v && in_valid) begin
                    q_rgb.push_back(model_pix(in_word, cfg_ext_variant, cfg_fmt565, cfg_rb_swap,
                                              cfg_be_byte, cfg_be_pix, mux_sel, 1'b0));
                    q_rgb.push_back(model_pix(in_word, cfg_ext_variant, cfg_fmt565, cfg_rb_swap,
                                              cfg_be_byte, cfg_be_pix, mux_sel, 1'b1));
                    q_tag.push_back(cur_tag);
                    q_tag.push_back(cur_tag);
                end
            end
        end
    end

    always @(posedge clk) begin
        #5;
        if (stall_mode == 0)      out_ready <= 1'b1;
        else if (stall_mode == 1) out_ready <= 1'($urandom % 2);
        else                      out_ready <= 1'b0;
    end

    task automatic send(logic [31:0] w, bit ext, bit fmt, bit bgr, bit beb, bit bep,
                        logic [1:0] mx, string tag);
        bit acc;
        @(posedge clk); #5;
        cur_tag = tag;
        in_word = w; cfg_ext_variant = ext; cfg_fmt565 = fmt; cfg_rb_swap = bgr;
        cfg_be_byte = beb; cfg_be_pix = bep; mux_sel = mx; in_valid = 1'b1;
        do begin
            @(negedge clk); acc = in_ready;
            @(posedge clk);
        end while (!acc);
        #5 in_valid = 1'b0;
    endtask

    task automatic drain();
        while (q_rgb.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            finish_run();
        end
    end

    localparam logic [31:0] W_A = 32'h1234_ABCD;
    localparam logic [31:0] W_B = 32'hF800_07E0;
    localparam logic [31:0] W_C = 32'h801F_FC00;

    initial begin
        repeat (3) @(negedge clk);
        @(posedge clk); #5 rst_n = 1'b1;
        // R3 little-endian order
        send(W_A, 1, 1, 0, 0, 0, 2'd0, "R3");
        send(W_B, 1, 1, 0, 0, 0, 2'd0, "R3");
        // R4 pixel order
        send(W_A, 1, 1, 0, 0, 1, 2'd0, "R4");
        send(W_C, 1, 0, 0, 0, 1, 2'd0, "R4");
        // R5 byte order wins
        send(W_A, 1, 1, 0, 1, 0, 2'd0, "R5");
        send(W_A, 1, 1, 0, 1, 1, 2'd0, "R5");
        send(W_B, 1, 0, 0, 1, 1, 2'd0, "R5");
        // R6 / R7 layouts and widening
        send(W_C, 1, 0, 0, 0, 0, 2'd0, "R6");
        send(32'hFFFF_8000, 1, 0, 0, 0, 0, 2'd0, "R6");
        send(W_B, 1, 1, 0, 0, 0, 2'd0, "R7");
        send(32'hFFFF_0000, 1, 1, 0, 0, 0, 2'd0, "R7");
        // R8 swap
        send(W_B, 1, 1, 1, 0, 0, 2'd0, "R8");
        send(W_C, 1, 0, 1, 0, 0, 2'd0, "R8");
        // R9 basic, select 1
        send(W_C, 0, 1, 0, 0, 0, 2'd1, "R9");
        send(W_C, 0, 1, 1, 0, 0, 2'd1, "R9");
        // R10 basic, select 3
        send(W_B, 0, 0, 0, 0, 0, 2'd3, "R10");
        send(W_B, 0, 0, 1, 0, 0, 2'd3, "R10");
        // R11 basic, select 0 and 2
        send(W_A, 0, 0, 0, 0, 0, 2'd0, "R11");
        send(W_A, 0, 0, 1, 0, 0, 2'd0, "R11");
        send(W_C, 0, 0, 0, 0, 0, 2'd2, "R11");
        send(W_C, 0, 0, 1, 0, 0, 2'd2, "R11");
        // R12 extended ignores select
        for (int m = 0; m < 4; m++) begin
            send(W_C, 1, 0, 0, 0, 0, 2'(m), "R12");
            send(W_B, 1, 1, 1, 0, 0, 2'(m), "R12");
        end
        drain();
        // R13 controls changed while pending
        stall_mode = 2;
        send(W_C, 0, 0, 0, 0, 0, 2'd2, "R13");
        #5;
        cfg_ext_variant = 1; cfg_fmt565 = 0; cfg_rb_swap = 1;
        cfg_be_byte = 1; cfg_be_pix = 1; mux_sel = 2'd3;
        repeat (4) @(posedge clk);
        stall_mode = 0;
        drain();
        // R2 random traffic under back-pressure
        stall_mode = 1;
        for (int k = 0; k < 300; k++) begin
            logic [9:0] r;
            r = 10'($urandom);
            send($urandom, r[0], r[1], r[2], r[3], r[4], r[6:5], "R2");
            if (r[9]) repeat (int'(r[8:7])) @(posedge clk);
        end
        drain();
        stall_mode = 0;
        finish_run();
    end
endmodule